// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Time

This block drives a three-phase motor bridge through six PWM pins, a high-side and a low-side pin for each phase. A 16-bit carrier counter climbs from zero to a working period value and falls back to zero. Each phase compares the carrier with its own compare register. The phase asks for its high-side pin while the carrier is at or above the compare value, and for its low-side pin otherwise. A per-phase dead-time counter holds back each side until its request has lasted for the programmed dead time. This gives a gap in which both switches of a leg are off.

Software writes a single register port. The half-period and compare values go into buffers. The buffers move into the working registers at the carrier crest, at the trough, or at both, as a mode field selects. A second set of compare addresses loads a compare register at once. The working period always equals the half-period buffer plus twice the dead time. The dead time and the two output polarity bits can only change while the generator is stopped.

The carrier is a three-state machine. The states are CAR_IDLE (stopped, counter held at 0), CAR_UP (counting up) and CAR_DOWN (counting down). The transitions are as follows. CAR_IDLE goes to CAR_UP when run is set; this cycle is the start cycle, and in it every working register is loaded. CAR_UP goes to CAR_DOWN at the crest. CAR_DOWN goes to CAR_UP at the trough. CAR_UP and CAR_DOWN both go to CAR_IDLE when run is cleared.

Top module: `tpwm_bridge`

## Requirements
- R1: The carrier counts up by one per clock from 0 to the working period P. The cycle with count P in the up direction raises `crest` for exactly one clock. The carrier then counts down from P-1. The cycle with count 0 in the down direction raises `trough` for exactly one clock. After that the up count restarts at 0. `count_down` is 1 throughout the down half.
- R2: At the start cycle, and at every selected transfer point, the working period becomes the half-period buffer (address 4) plus twice the dead time (address 3).
- R3: Address 1 bits [1:0] select the transfer points: bit 0 selects the crest and bit 1 the trough; 2'b00 selects none. A period moved at the crest first bounds the up count of the following carrier period. A period moved at the trough bounds the up half that starts right after that trough.
- R4: Compare buffers for phases 0, 1 and 2 sit at addresses 5, 6 and 7. They accept writes at any time, and their contents reach the compare registers only at the start cycle or a selected transfer point. If a buffer write lands in the same cycle as a transfer, the previous buffer contents are the ones moved, and the new value waits for the next transfer.
- R5: A write to address 8, 9 or 10 loads both the compare register and the buffer of phase 0, 1 or 2 in the same clock, whatever the mode.
- R6: A phase requests its high side while count >= compare, and its low side otherwise. A side becomes active only once its request has lasted Td clocks. With Td > 0 the two sides of a phase are never active together, and a Td-clock gap separates them.
- R7: Address 2 bit 0 sets the active level of all three high-side pins, and bit 1 sets it for all three low-side pins (1 = active high). An inactive pin drives the inverse of its active level.
- R8: In the first running cycle each phase's output follows its compare buffer value B. With B = 0 the high side is active and the low side inactive. With 1 <= B <= Td both sides are inactive. With B > Td the high side is inactive and the low side active.
- R9: Writes to the dead time and to the polarity bits take effect only while run is clear and the carrier is idle. Such writes made while running are ignored.
- R10: Address 0 bit 0 is run. Two clocks after run is cleared, all six pins are at their inactive level, the count is 0 and `count_down` is 0.
- R11: After reset: run is 0, the polarity bits are 2'b11, the dead time, mode, buffers and compare registers are 0, all pins are low, and `crest`, `trough` and the count are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_hi | output | 3 | High-side pins, bit n = phase n |
| pwm_lo | output | 3 | Low-side pins, bit n = phase n |
| carrier_cnt | output | 16 | Carrier count |
| count_down | output | 1 | 1 while the carrier counts down |
| crest | output | 1 | One-clock crest flag |
| trough | output | 1 | One-clock trough flag |

## Verification
Two functions can fall on the same clock: a software write to a compare buffer, and the crest transfer that copies that buffer into its compare register. The bench waits until it sees `crest` high. It then issues a buffer write that lands on the very edge that closes the crest cycle. It judges the result from the low-side/high-side pattern of the phase at the following trough, which must still reflect the old compare value. A second pattern, one full carrier period later, must show the new value.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    typedef enum logic [1:0] {
        CAR_IDLE = 2'd0,
        CAR_UP   = 2'd1,
        CAR_DOWN = 2'd2
    } car_state_t;

    localparam int ADDR_W  = 4;
    localparam int A_RUN   = 0;
    localparam int A_MODE  = 1;
    localparam int A_POL   = 2;
    localparam int A_DEAD  = 3;
    localparam int A_HALF  = 4;
    localparam int A_CBUF0 = 5;
    localparam int A_CIMM0 = 8;

endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
    import tpwm_pkg::*;
#(
    parameter int W   = 16,
    parameter int NPH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              running,
    input  logic              start,
    input  logic              crest,
    input  logic              trough,
    output logic              run_en,
    output logic              pol_hi,
    output logic              pol_lo,
    output logic [W-1:0]      td,
    output logic [W-1:0]      period_w,
    output logic [W-1:0]      cmp_w   [NPH],
    output logic [W-1:0]      cmp_buf [NPH]
);

    logic [1:0]   mode_q;
    logic [W-1:0] half_buf;
    logic         locked;
    logic         xfer;

    // Polarity and dead time are frozen from the run write until the carrier is idle again.
    assign locked = run_en | running;
    assign xfer   = start | (crest & mode_q[0]) | (trough & mode_q[1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            mode_q   <= 2'b00;
            pol_hi   <= 1'b1;
            pol_lo   <= 1'b1;
            td       <= '0;
            half_buf <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_RUN))
                run_en <= wr_data[0];
            if (wr_addr == ADDR_W'(A_MODE))
                mode_q <= wr_data[1:0];
            if (wr_addr == ADDR_W'(A_POL) && !locked) begin
                pol_hi <= wr_data[0];
                pol_lo <= wr_data[1];
            end
            if (wr_addr == ADDR_W'(A_DEAD) && !locked)
                td <= wr_data;
            if (wr_addr == ADDR_W'(A_HALF))
                half_buf <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            period_w <= '0;
        else if (xfer)
            period_w <= half_buf + {td[W-2:0], 1'b0};
    end

    // Buffered and immediate compare paths; the immediate write overrides a transfer in the same clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPH; p++) begin
                cmp_buf[p] <= '0;
                cmp_w[p]   <= '0;
            end
        end else begin
            for (int p = 0; p < NPH; p++) begin
                if (wr_en && wr_addr == ADDR_W'(A_CIMM0 + p)) begin
                    cmp_buf[p] <= wr_data;
                    cmp_w[p]   <= wr_data;
                end else begin
                    if (wr_en && wr_addr == ADDR_W'(A_CBUF0 + p))
                        cmp_buf[p] <= wr_data;
                    if (xfer)
                        cmp_w[p] <= cmp_buf[p];
                end
            end
        end
    end

    AST_POL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> ($stable(pol_hi) && $stable(pol_lo)));   // R9
    AST_TD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> $stable(td));                             // R9

    for (genvar g = 0; g < NPH; g++) begin : g_imm_chk
        AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(A_CIMM0 + g)) |=> (cmp_w[g] == $past(wr_data)));   // R5
    end

endmodule

// File: rtl/tpwm_carrier.sv
module tpwm_carrier
    import tpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] period_w,
    output logic [W-1:0] cnt,
    output logic         count_down,
    output logic         crest,
    output logic         trough,
    output logic         running,
    output logic         start
);

    car_state_t   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CAR_IDLE: begin
                cnt_d = '0;
                if (run_en)
                    state_d = CAR_UP;
            end
            CAR_UP: begin
                if (!run_en) begin
                    state_d = CAR_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q >= period_w) begin
                    state_d = CAR_DOWN;
                    cnt_d   = (cnt_q == '0) ? '0 : cnt_q - W'(1);
                end else begin
                    cnt_d = cnt_q + W'(1);
                end
            end
            CAR_DOWN: begin
                if (!run_en) begin
                    state_d = CAR_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == '0) begin
                    state_d = CAR_UP;
                end else begin
                    cnt_d = cnt_q - W'(1);
                end
            end
            default: begin
                state_d = CAR_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        cnt        = cnt_q;
        count_down = (state_q == CAR_DOWN);
        running    = (state_q != CAR_IDLE);
        start      = (state_q == CAR_IDLE) && run_en;
        crest      = (state_q == CAR_UP)   && run_en && (cnt_q >= period_w);
        trough     = (state_q == CAR_DOWN) && run_en && (cnt_q == '0);
    end

    AST_CREST_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        crest |=> !crest);                                          // R1
    AST_TROUGH_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        trough |=> (!trough && state_q == CAR_UP));                 // R1
    AST_UP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAR_UP) |-> (cnt_q <= period_w));               // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAR_IDLE) |-> (cnt_q == '0));                   // R10

endmodule

// File: rtl/tpwm_phase.sv
module tpwm_phase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         running,
    input  logic         start,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] cmp_init,
    input  logic [W-1:0] td,
    input  logic         pol_hi,
    input  logic         pol_lo,
    output logic         pin_hi,
    output logic         pin_lo
);

    logic [W-1:0] hi_dt, lo_dt;
    logic         hi_req, hi_act, lo_act;

    assign hi_req = (cnt >= cmp);

    // The start preset reproduces the first-output rule: a side whose request already
    // holds at start is treated as settled, otherwise it waits out the dead time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_dt <= '0;
            lo_dt <= '0;
        end else if (start) begin
            hi_dt <= (cmp_init == '0) ? td : '0;
            lo_dt <= (cmp_init > td)  ? td : '0;
        end else if (!running) begin
            hi_dt <= '0;
            lo_dt <= '0;
        end else if (hi_req) begin
            lo_dt <= '0;
            if (hi_dt < td)
                hi_dt <= hi_dt + W'(1);
        end else begin
            hi_dt <= '0;
            if (lo_dt < td)
                lo_dt <= lo_dt + W'(1);
        end
    end

    always_comb begin
        hi_act = running &&  hi_req && (hi_dt >= td);
        lo_act = running && !hi_req && (lo_dt >= td);
        pin_hi = hi_act ? pol_hi : ~pol_hi;
        pin_lo = lo_act ? pol_lo : ~pol_lo;
    end

    AST_DT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((td != '0) && $fell(lo_act)) |-> !hi_act);                 // R6
    AST_DT_GAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ((td != '0) && $fell(hi_act)) |-> !lo_act);                 // R6

endmodule

// File: rtl/tpwm_bridge.sv
module tpwm_bridge
    import tpwm_pkg::*;
#(
    parameter int W   = 16,
    parameter int NPH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [NPH-1:0]    pwm_hi,
    output logic [NPH-1:0]    pwm_lo,
    output logic [W-1:0]      carrier_cnt,
    output logic              count_down,
    output logic              crest,
    output logic              trough
);

    logic         run_en, pol_hi, pol_lo, running, start;
    logic [W-1:0] td, period_w;
    logic [W-1:0] cmp_w   [NPH];
    logic [W-1:0] cmp_buf [NPH];

    tpwm_regs #(.W(W), .NPH(NPH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .running  (running),
        .start    (start),
        .crest    (crest),
        .trough   (trough),
        .run_en   (run_en),
        .pol_hi   (pol_hi),
        .pol_lo   (pol_lo),
        .td       (td),
        .period_w (period_w),
        .cmp_w    (cmp_w),
        .cmp_buf  (cmp_buf)
    );

    tpwm_carrier #(.W(W)) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .period_w   (period_w),
        .cnt        (carrier_cnt),
        .count_down (count_down),
        .crest      (crest),
        .trough     (trough),
        .running    (running),
        .start      (start)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        tpwm_phase #(.W(W)) u_phase (
            .clk      (clk),
            .rst_n    (rst_n),
            .running  (running),
            .start    (start),
            .cnt      (carrier_cnt),
            .cmp      (cmp_w[p]),
            .cmp_init (cmp_buf[p]),
            .td       (td),
            .pol_hi   (pol_hi),
            .pol_lo   (pol_lo),
            .pin_hi   (pwm_hi[p]),
            .pin_lo   (pwm_lo[p])
        );
    end

endmodule

// File: tb/tpwm_bridge_tb.sv
module tpwm_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  pwm_hi, pwm_lo;
    logic [15:0] carrier_cnt;
    logic        count_down, crest, trough;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int c;

    always #5 clk = ~clk;

    tpwm_bridge u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_hi      (pwm_hi),
        .pwm_lo      (pwm_lo),
        .carrier_cnt (carrier_cnt),
        .count_down  (count_down),
        .crest       (crest),
        .trough      (trough)
    );

    // First up half, down half and the next trough with Td=2, P=14, compares 0 / 2 / 5, active-high.
    localparam int       NV = 13;
    localparam logic     V_DN  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0};
    localparam int       V_CNT [NV] = '{0, 1, 3, 4, 5, 6, 7, 14, 4, 2, 1, 0, 0};
    localparam logic [2:0] V_HI [NV] = '{3'b001, 3'b001, 3'b001, 3'b011, 3'b011, 3'b011, 3'b111,
                                         3'b111, 3'b011, 3'b011, 3'b001, 3'b001, 3'b001};
    localparam logic [2:0] V_LO [NV] = '{3'b100, 3'b100, 3'b100, 3'b100, 3'b000, 3'b000, 3'b000,
                                         3'b000, 3'b000, 3'b100, 3'b100, 3'b100, 3'b110};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = 16'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic step_to(input logic dn, input int cv);
        int n = 0;
        do begin
            @(posedge clk);
            #2;
            n++;
        end while (!(count_down == dn && carrier_cnt == 16'(cv)) && n < 400);
        if (n >= 400) chk("R1 carrier position not reached", 32'(carrier_cnt), 32'(cv));
    endtask

    task automatic to_crest(output int cv);
        int n = 0;
        do begin
            @(posedge clk);
            #2;
            n++;
        end while (!crest && n < 400);
        if (n >= 400) chk("R1 crest not reached", 0, 1);
        cv = int'(carrier_cnt);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R11 reset pwm_hi", 32'(pwm_hi), 0);
        chk("R11 reset pwm_lo", 32'(pwm_lo), 0);
        chk("R11 reset cnt/flags", {carrier_cnt, 13'd0, count_down, crest, trough}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        wr(3, 2);  wr(4, 10);
        wr(5, 0);  wr(6, 2);  wr(7, 5);
        wr(2, 3);  wr(1, 1);  wr(0, 1);

        // R6 R8 R1 vector table walk
        for (int i = 0; i < NV; i++) begin
            step_to(V_DN[i], V_CNT[i]);
            chk($sformatf("R6 vec%0d pwm_hi", i), 32'(pwm_hi), 32'(V_HI[i]));
            chk($sformatf("R6 vec%0d pwm_lo", i), 32'(pwm_lo), 32'(V_LO[i]));
            if (V_CNT[i] == 14) chk("R1 crest flag at P", 32'(crest), 1);
            if (V_DN[i] && V_CNT[i] == 0) chk("R1 trough flag", 32'(trough), 1);
        end

        // R4 buffered compare write waits for the crest
        wr(5, 8);
        step_to(0, 3);
        chk("R4 buffer not yet applied", 32'(pwm_hi[0]), 1);
        step_to(1, 7);
        chk("R4 compare moved at crest (hi)", 32'(pwm_hi[0]), 0);
        chk("R4 compare moved at crest (lo)", 32'(pwm_lo[0]), 0);
        step_to(1, 5);
        chk("R4 low side after gap", 32'(pwm_lo[0]), 1);

        // R5 immediate compare write
        step_to(0, 1);
        wr(9, 12);
        step_to(0, 10);
        chk("R5 immediate hi", 32'(pwm_hi[1]), 0);
        chk("R5 immediate lo", 32'(pwm_lo[1]), 1);

        // R2 R3 crest-timed period change
        step_to(1, 12);
        wr(4, 6);
        to_crest(c);
        chk("R3 crest transfer keeps current crest", 32'(c), 14);
        @(posedge clk);
        #2;
        chk("R1 crest one clock / direction", {30'd0, crest, count_down}, 1);
        to_crest(c);
        chk("R2 period = half + 2Td", 32'(c), 10);

        // R9 polarity and dead-time writes ignored while running
        wr(2, 0);
        wr(3, 0);
        step_to(0, 9);
        chk("R9 locked pwm_hi", 32'(pwm_hi), 32'(3'b100));
        chk("R9 locked pwm_lo", 32'(pwm_lo), 32'(3'b010));

        // R3 trough-timed period change
        wr(1, 2);
        step_to(1, 5);
        wr(4, 4);
        to_crest(c);
        chk("R3 trough transfer same period", 32'(c), 8);

        // R10 stop
        wr(0, 0);
        repeat (2) @(posedge clk);
        #2;
        chk("R10 stop pins", {26'd0, pwm_hi, pwm_lo}, 0);
        chk("R10 stop counter", {15'd0, count_down, carrier_cnt}, 0);

        // R7 R9 polarity and dead time accepted while stopped
        wr(2, 0);
        #1;
        chk("R7 inactive-low-polarity idle", {26'd0, pwm_hi, pwm_lo}, 32'h3F);
        wr(3, 3);
        wr(7, 2);
        wr(8, 0);
        wr(0, 1);
        step_to(0, 0);
        chk("R8 initial pwm_hi", 32'(pwm_hi), 32'(3'b110));
        chk("R8 initial pwm_lo", 32'(pwm_lo), 32'(3'b101));
        step_to(0, 4);
        chk("R9 new Td gap", 32'(pwm_hi[2]), 1);
        step_to(0, 5);
        chk("R9 new Td end", 32'(pwm_hi[2]), 0);
        to_crest(c);
        chk("R2 period after Td change", 32'(c), 10);

        // R4 buffer write in the crest transfer cycle
        wr(1, 1);
        to_crest(c);
        wr(7, 0);
        step_to(1, 0);
        chk("R4 same-cycle write held back", 32'(pwm_hi[2]), 1);
        to_crest(c);
        step_to(1, 0);
        chk("R4 held value moved next crest", 32'(pwm_hi[2]), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule